// File: doc/BRIEF.md
# Two-Slot Audio Serial Transmitter

The block turns a stereo sample pair into a continuous serial stream that is timed by a bit clock. Each frame holds two 32-bit slots, left first, then right. A slot carries a 24-bit audio field, a user bit, a channel-status bit and a block-start marker. Its other positions are fixed at zero. A frame-sync line marks which slot is on the wire, and it switches one bit period before the slot it announces.

The block owns all of its timing. It latches a new pair at each frame boundary and raises a one-bit-period ready pulse. The source then has the rest of the frame to present the following pair. A 20-bit mode clears the upper four audio positions of both slots. A frame counter that runs from 0 to 191 sets the block-start marker on its own, once every 192 frames.

All state changes on the falling edge of the bit clock, so the data and sync lines are stable at each rising edge.

Top module: `audslot_tx`

## Requirements
- R1: A frame lasts 64 bit periods. The left slot goes out first, then the right slot. Each slot is sent from position 31 down to position 0, one position per bit period, and outputs change only on the falling edge of `bitClk`.
- R2: `lrck` is low while the left slot is sent and high while the right slot is sent. Counting the bit periods of a frame from 0, it is high in periods 31 through 62, so each change comes one period before the first bit of the slot it marks.
- R3: Slot positions 0, 25, 26, 27 and 31 are always 0.
- R4: With `mode20` low, sample bits 23..0 appear at slot positions 24..1.
- R5: With `mode20` high, slot positions 24..21 are 0 and sample bits 19..0 appear at positions 20..1.
- R6: Each slot carries its channel's user bit at position 29 and its channel-status bit at position 30.
- R7: Position 28 is the block-start marker. It is 1 in the left slot of frame 0 of every run of 192 frames and 0 in every other slot, including all right slots.
- R8: The sample pair, the flags and `mode20` are latched on the falling edge that starts a frame. `sampleReady` is high for exactly the first bit period of each frame and low otherwise.
- R9: While `rstN` is low at a falling edge, `sdata`, `lrck` and `sampleReady` are held at 0 and the frame counter is restarted. The first falling edge with `rstN` high latches a pair and starts frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Serial bit clock; all state updates on its falling edge |
| rstN | input | 1 | Synchronous active-low reset |
| leftSample | input | 24 | Left audio sample |
| rightSample | input | 24 | Right audio sample |
| leftUser | input | 1 | User bit for the left slot |
| leftChan | input | 1 | Channel-status bit for the left slot |
| rightUser | input | 1 | User bit for the right slot |
| rightChan | input | 1 | Channel-status bit for the right slot |
| mode20 | input | 1 | 1 selects 20-bit audio, 0 selects 24-bit |
| sampleReady | output | 1 | One-period pulse when a new pair has been latched |
| sdata | output | 1 | Serial slot data |
| lrck | output | 1 | Frame sync: low for the left slot, high for the right |

## Verification
The bench collects all 64 bits of each frame and compares them against slots it builds itself. Samples with all ones in the top nibble are sent in 20-bit mode; a design that left positions 24..21 unmasked would send ones there. The bench runs past frame 192 to confirm that the block-start marker comes back on that frame and on no other. An off-by-one in the wrap would move the marker or drop it. A reset applied in the middle of a frame must restart the stream with the marker set, and the bench checks the exact period where `lrck` rises. A sync line without the one-bit lead would go high one period late, at bit period 32.

// File: rtl/audslot_pkg.sv
package audslot_pkg;

  // Fixed slot layout
  localparam int AUD_LSB = 1;
  localparam int Z_POS   = 28;
  localparam int U_POS   = 29;
  localparam int C_POS   = 30;
  // Reserved positions 31, 27, 26, 25 and 0
  localparam logic [31:0] RSV_MASK = 32'h8E00_0001;

  typedef struct packed {
    logic load;        // latch a new pair into the shifter
    logic shift;       // advance the shifter by one bit
    logic blockStart;  // the frame being loaded is frame 0 of a block
  } strobe_t;

endpackage

// File: rtl/audslot_ctrl.sv
module audslot_ctrl #(
  parameter int SLOT_W    = 32,
  parameter int BLOCK_LEN = 192
) (
  input  logic                  bitClk,
  input  logic                  rstN,
  output audslot_pkg::strobe_t  strb,
  output logic                  lrck,
  output logic                  ready
);
  localparam int FRAME_BITS = 2 * SLOT_W;
  localparam int CW = $clog2(FRAME_BITS);
  localparam int FW = $clog2(BLOCK_LEN);
  localparam logic [CW-1:0] LAST_BIT  = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] SYNC_HI   = CW'(SLOT_W - 1);
  localparam logic [CW-1:0] SYNC_LO   = CW'(FRAME_BITS - 2);
  localparam logic [FW-1:0] LAST_FRM  = FW'(BLOCK_LEN - 1);

  logic [CW-1:0] bitCnt, bitNext;
  logic [FW-1:0] frameCnt, frameNext;
  logic          frameEnd;

  always_comb begin
    frameEnd  = (bitCnt == LAST_BIT);
    bitNext   = frameEnd ? '0 : bitCnt + 1'b1;
    frameNext = (frameCnt == LAST_FRM) ? '0 : frameCnt + 1'b1;
    strb.load       = frameEnd;
    strb.shift      = !frameEnd;
    strb.blockStart = frameEnd && (frameNext == '0);
  end

  always_ff @(negedge bitClk) begin
    if (!rstN) begin
      bitCnt   <= LAST_BIT;
      frameCnt <= LAST_FRM;
      lrck     <= 1'b0;
      ready    <= 1'b0;
    end else begin
      bitCnt <= bitNext;
      if (frameEnd) frameCnt <= frameNext;
      lrck  <= (bitNext >= SYNC_HI) && (bitNext <= SYNC_LO);
      ready <= frameEnd;
    end
  end

endmodule

// File: rtl/audslot_dp.sv
module audslot_dp #(
  parameter int SLOT_W  = 32,
  parameter int AUDIO_W = 24,
  parameter int SHORT_W = 20
) (
  input  logic                     bitClk,
  input  logic                     rstN,
  input  audslot_pkg::strobe_t     strb,
  input  logic [1:0][AUDIO_W-1:0]  samples,
  input  logic [1:0]               userBits,
  input  logic [1:0]               chanBits,
  input  logic                     mode20,
  output logic                     sdata
);
  import audslot_pkg::*;
  localparam int FRAME_BITS = 2 * SLOT_W;
  localparam int PAD_W = AUDIO_W - SHORT_W;

  logic [FRAME_BITS-1:0] shReg;

  // channel 0 = left, channel 1 = right
  for (genvar ch = 0; ch < 2; ch++) begin : g_slot
    logic [SLOT_W-1:0] word;
    always_comb begin
      word = '0;
      word[AUD_LSB +: AUDIO_W] = samples[ch];
      if (mode20) word[AUD_LSB + SHORT_W +: PAD_W] = '0;
      word[U_POS] = userBits[ch];
      word[C_POS] = chanBits[ch];
      word[Z_POS] = (ch == 0) ? strb.blockStart : 1'b0;
    end
  end

  always_ff @(negedge bitClk) begin
    if (!rstN)          shReg <= '0;
    else if (strb.load) shReg <= {g_slot[0].word, g_slot[1].word};
    else if (strb.shift) shReg <= {shReg[FRAME_BITS-2:0], 1'b0};
  end

  assign sdata = shReg[FRAME_BITS-1];

endmodule

// File: rtl/audslot_tx.sv
module audslot_tx #(
  parameter int SLOT_W    = 32,
  parameter int AUDIO_W   = 24,
  parameter int SHORT_W   = 20,
  parameter int BLOCK_LEN = 192
) (
  input  logic               bitClk,
  input  logic               rstN,
  input  logic [AUDIO_W-1:0] leftSample,
  input  logic [AUDIO_W-1:0] rightSample,
  input  logic               leftUser,
  input  logic               leftChan,
  input  logic               rightUser,
  input  logic               rightChan,
  input  logic               mode20,
  output logic               sampleReady,
  output logic               sdata,
  output logic               lrck
);
  audslot_pkg::strobe_t strb;

  audslot_ctrl #(.SLOT_W(SLOT_W), .BLOCK_LEN(BLOCK_LEN)) u_ctrl (
    .bitClk (bitClk),
    .rstN   (rstN),
    .strb   (strb),
    .lrck   (lrck),
    .ready  (sampleReady)
  );

  audslot_dp #(.SLOT_W(SLOT_W), .AUDIO_W(AUDIO_W), .SHORT_W(SHORT_W)) u_dp (
    .bitClk   (bitClk),
    .rstN     (rstN),
    .strb     (strb),
    .samples  ({rightSample, leftSample}),
    .userBits ({rightUser, leftUser}),
    .chanBits ({rightChan, leftChan}),
    .mode20   (mode20),
    .sdata    (sdata)
  );

endmodule

// File: rtl/audslot_chk.sv
module audslot_chk #(
  parameter int SLOT_W = 32
) (
  input logic bitClk,
  input logic rstN,
  input logic sampleReady,
  input logic sdata,
  input logic lrck
);
  localparam int PW = $clog2(2 * SLOT_W);
  localparam int SW = $clog2(SLOT_W);

  logic [PW-1:0] phase;
  logic [SW-1:0] slotPos;
  logic          rsvHit;

  always_ff @(negedge bitClk) begin
    if (!rstN) phase <= PW'(2 * SLOT_W - 1);
    else       phase <= phase + 1'b1;
  end

  always_comb begin
    slotPos = SW'(SLOT_W - 1) - phase[SW-1:0];
    rsvHit  = audslot_pkg::RSV_MASK[slotPos];
  end

  AST_READY_AT_START: assert property (@(negedge bitClk) disable iff (!rstN)
    sampleReady |-> (phase == '0)); // R8
  AST_READY_EVERY_FRAME: assert property (@(negedge bitClk) disable iff (!rstN)
    (phase == '0) |-> sampleReady); // R8
  AST_SYNC_SHAPE: assert property (@(negedge bitClk) disable iff (!rstN)
    lrck == ((phase >= PW'(SLOT_W - 1)) && (phase <= PW'(2 * SLOT_W - 2)))); // R2
  AST_RSV_ZERO: assert property (@(negedge bitClk) disable iff (!rstN)
    rsvHit |-> !sdata); // R3
  AST_RIGHT_NO_BLOCK: assert property (@(negedge bitClk) disable iff (!rstN)
    (phase == PW'(SLOT_W + SLOT_W - 1 - audslot_pkg::Z_POS)) |-> !sdata); // R7

endmodule

bind audslot_tx audslot_chk #(.SLOT_W(SLOT_W)) u_chk (
  .bitClk      (bitClk),
  .rstN        (rstN),
  .sampleReady (sampleReady),
  .sdata       (sdata),
  .lrck        (lrck)
);

// File: tb/audslot_tx_bench.sv
`timescale 1ns/1ps
module audslot_tx_bench;

  typedef struct packed {
    logic        m20;
    logic [23:0] l;
    logic [23:0] r;
    logic        lu, lc, ru, rc;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 24'h800001, 24'h7FFFFE, 1'b1, 1'b0, 1'b0, 1'b1},
    '{1'b0, 24'hFFFFFF, 24'h000000, 1'b1, 1'b1, 1'b1, 1'b1},
    '{1'b1, 24'hFFFFFF, 24'hABCDEF, 1'b0, 1'b1, 1'b1, 1'b0},
    '{1'b0, 24'h123456, 24'hFEDCBA, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 24'h0F0F0F, 24'hF0F0F0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b0, 24'hAAAAAA, 24'h555555, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  logic bitClk = 1'b0;
  logic rstN = 1'b0;
  logic [23:0] leftSample = '0, rightSample = '0;
  logic leftUser = 0, leftChan = 0, rightUser = 0, rightChan = 0, mode20 = 0;
  logic sampleReady, sdata, lrck;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 bitClk = ~bitClk;

  audslot_tx u_audslot_tx (
    .bitClk(bitClk), .rstN(rstN),
    .leftSample(leftSample), .rightSample(rightSample),
    .leftUser(leftUser), .leftChan(leftChan),
    .rightUser(rightUser), .rightChan(rightChan),
    .mode20(mode20), .sampleReady(sampleReady),
    .sdata(sdata), .lrck(lrck)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkSlot(logic [23:0] s, logic u, logic c, logic z, logic m20);
    logic [31:0] w = '0;
    w[24:1] = s;
    if (m20) w[24:21] = 4'h0;
    w[28] = z; w[29] = u; w[30] = c;
    return w;
  endfunction

  task automatic applyVec(input vec_t v);
    leftSample = v.l; rightSample = v.r;
    leftUser = v.lu; leftChan = v.lc; rightUser = v.ru; rightChan = v.rc;
    mode20 = v.m20;
  endtask

  // Inputs are applied, then the next falling edge latches them.
  task automatic runFrame(input vec_t v, input int fidx);
    logic [63:0] got = '0, gotSync = '0, gotRdy = '0;
    logic [63:0] exp, expSync, expRdy, audMask, ucMask, rsvMask;
    logic z;
    z = ((fidx % 192) == 0);
    applyVec(v);
    for (int k = 0; k < 64; k++) begin
      @(negedge bitClk);
      @(posedge bitClk);
      got[63-k] = sdata; gotSync[63-k] = lrck; gotRdy[63-k] = sampleReady;
    end
    exp = {mkSlot(v.l, v.lu, v.lc, z, v.m20), mkSlot(v.r, v.ru, v.rc, 1'b0, v.m20)};
    expSync = '0;
    for (int k = 31; k <= 62; k++) expSync[63-k] = 1'b1;
    expRdy = 64'h8000_0000_0000_0000;
    audMask = {2{32'h01FF_FFFE}};
    ucMask  = {2{32'h6000_0000}};
    rsvMask = {2{32'h8E00_0001}};
    chk(got == exp, "R1", $sformatf("frame %0d full bit order", fidx), got, exp);
    chk((got & rsvMask) == 64'h0, "R3", $sformatf("frame %0d reserved", fidx), got & rsvMask, 64'h0);
    chk((got & audMask) == (exp & audMask), v.m20 ? "R5" : "R4",
        $sformatf("frame %0d audio", fidx), got & audMask, exp & audMask);
    chk((got & ucMask) == (exp & ucMask), "R6", $sformatf("frame %0d user/status", fidx),
        got & ucMask, exp & ucMask);
    chk({got[60], got[28]} == {z, 1'b0}, "R7", $sformatf("frame %0d block marker", fidx),
        64'({got[60], got[28]}), 64'({z, 1'b0}));
    chk(gotSync == expSync, "R2", $sformatf("frame %0d lrck", fidx), gotSync, expSync);
    chk(gotRdy == expRdy, "R8", $sformatf("frame %0d ready", fidx), gotRdy, expRdy);
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "WATCHDOG", "run timed out", 64'(checks), 64'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R9: reset state
    applyVec(VECS[0]);
    repeat (3) @(posedge bitClk);
    chk({sdata, lrck, sampleReady} == 3'b000, "R9", "outputs in reset",
        64'({sdata, lrck, sampleReady}), 64'h0);
    rstN = 1'b1;

    // Table walk, then continue past the 192-frame block boundary (R7)
    for (int f = 0; f < 194; f++) runFrame(VECS[f % NVEC], f);

    // R9: reset in the middle of a frame restarts at frame 0
    applyVec(VECS[3]);
    repeat (10) @(negedge bitClk);
    @(posedge bitClk);
    rstN = 1'b0;
    @(negedge bitClk);
    @(posedge bitClk);
    chk({sdata, lrck, sampleReady} == 3'b000, "R9", "outputs after mid-frame reset",
        64'({sdata, lrck, sampleReady}), 64'h0);
    @(negedge bitClk);
    @(posedge bitClk);
    rstN = 1'b1;
    runFrame(VECS[2], 0);
    runFrame(VECS[5], 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule